// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block decodes one instruction of a compact variable-length instruction set. Each cycle it can accept a six-byte window of instruction memory together with the address of the window's first byte. From the first byte alone it works out the instruction class and length. It then extracts the two register specifiers and assembles the 32-bit little-endian constant, which is an immediate, a displacement or a jump target depending on the class. It also reports the address of the following instruction, and flags codes it does not recognise.

The result is held in one output register stage with a valid/ready handshake on both sides. A fetch unit can stream windows through at one per cycle while the consumer accepts, and the stage holds its result steady while the consumer stalls. Register file access, execution and memory traffic belong to other blocks.

Top module: `insn_window_decoder`

## Requirements
- R1: Length is taken from byte 0 alone: codes 0x00 and 0x10 give 1; 0x20 and 0x60..0x63 give 2; 0x70..0x76 give 5; 0x30, 0x40 and 0x50 give 6.
- R2: The opcode output is byte 0 bits [7:4] and the function output is byte 0 bits [3:0], for every window including invalid ones.
- R3: For classes with a register byte (0x2_, 0x3_, 0x4_, 0x5_, 0x6_), rA is byte 1 bits [7:4] and rB is byte 1 bits [3:0]. All other windows report 8 (no register) for both.
- R4: The constant is bytes 2..5 for 0x30/0x40/0x50 and bytes 1..4 for jumps, with the lowest-addressed byte least significant. Every other window reports zero.
- R5: The next address output equals the window address plus the decoded length, modulo 2^32.
- R6: An opcode above 7, or a function code out of range (above 3 for opcode 6, above 6 for opcode 7, nonzero for every other opcode), sets invalid. It reports length 1, rA = rB = 8 and constant 0.
- R7: The halt output is 1 exactly for a valid 0x10 window. It is 0 for anything invalid.
- R8: in_ready is 1 whenever the output stage is empty or out_ready is 1. While out_valid is 1 and out_ready is 0, every output stays unchanged.
- R9: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A window is offered |
| in_ready | output | 1 | The decoder takes the window this cycle |
| in_pc | input | 32 | Address of window byte 0 |
| in_window | input | 48 | Instruction bytes, byte k in bits [8k+7:8k] |
| out_valid | output | 1 | A decoded result is held |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_icode | output | 4 | Opcode nibble |
| out_ifun | output | 4 | Function nibble |
| out_ra | output | 4 | First register specifier, 8 when absent |
| out_rb | output | 4 | Second register specifier, 8 when absent |
| out_const | output | 32 | Assembled constant, 0 when absent |
| out_len | output | 3 | Instruction length in bytes |
| out_next_pc | output | 32 | Address of the following instruction |
| out_invalid | output | 1 | Unrecognised code |
| out_halt | output | 1 | Halt instruction decoded |

## Verification
Two things can land on the same clock edge. One is the consumer draining the held result. The other is the fetch side loading a new window into the same register. The bench provokes this by driving out_ready and in_valid at random, so back-to-back transfers alternate with stalls. Every result that leaves is compared, in order, against a queue of expected decodes built when each window was accepted. A window lost, repeated or overwritten during a stall therefore shows up as a mismatch.

// File: rtl/ixd_pkg.sv
package ixd_pkg;

   localparam logic [3:0] NOREG_ID = 4'h8;

   typedef enum logic [1:0] {
      CP_NONE = 2'd0,
      CP_AT1  = 2'd1,
      CP_AT2  = 2'd2
   } const_pos_e;

   typedef struct packed {
      logic       ok;
      logic [2:0] len;
      logic       has_reg;
      const_pos_e cpos;
      logic       halt;
   } ixd_class_t;

endpackage

// File: rtl/ixd_classify.sv
module ixd_classify
   import ixd_pkg::*;
(
   input  logic [7:0]  op_byte,
   output ixd_class_t  cls
);

   logic [3:0] icode;
   logic [3:0] ifun;

   assign icode = op_byte[7:4];
   assign ifun  = op_byte[3:0];

   always_comb begin
      cls = '{ok: 1'b0, len: 3'd1, has_reg: 1'b0, cpos: CP_NONE, halt: 1'b0};
      unique case (icode)
         4'h0: begin
            cls.ok = (ifun == 4'h0);
         end
         4'h1: begin
            cls.ok   = (ifun == 4'h0);
            cls.halt = (ifun == 4'h0);
         end
         4'h2: begin
            cls.ok = (ifun == 4'h0);
            if (cls.ok) begin
               cls.len     = 3'd2;
               cls.has_reg = 1'b1;
            end
         end
         4'h3, 4'h4, 4'h5: begin
            cls.ok = (ifun == 4'h0);
            if (cls.ok) begin
               cls.len     = 3'd6;
               cls.has_reg = 1'b1;
               cls.cpos    = CP_AT2;
            end
         end
         4'h6: begin
            cls.ok = (ifun <= 4'h3);
            if (cls.ok) begin
               cls.len     = 3'd2;
               cls.has_reg = 1'b1;
            end
         end
         4'h7: begin
            cls.ok = (ifun <= 4'h6);
            if (cls.ok) begin
               cls.len  = 3'd5;
               cls.cpos = CP_AT1;
            end
         end
         default: begin
            cls.ok = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/ixd_fields.sv
module ixd_fields
   import ixd_pkg::*;
#(
   parameter int WIN_BYTES = 6,
   parameter int CONST_W   = 32,
   localparam int WIN_W       = 8 * WIN_BYTES,
   localparam int CONST_BYTES = CONST_W / 8
)(
   input  logic [WIN_W-1:0]   window,
   input  ixd_class_t         cls,
   output logic [3:0]         ra,
   output logic [3:0]         rb,
   output logic [CONST_W-1:0] cst
);

   logic [CONST_W-1:0] cst_at1;
   logic [CONST_W-1:0] cst_at2;

   generate
      if (CONST_W % 8 != 0) begin : g_bad_cw
         $error("ixd_fields: CONST_W must be a whole number of bytes");
      end
      if (WIN_BYTES < 2 + CONST_BYTES) begin : g_bad_win
         $error("ixd_fields: window too short for register byte plus constant");
      end
      for (genvar g = 0; g < CONST_BYTES; g++) begin : g_cbyte
         assign cst_at1[8*g +: 8] = window[8*(1+g) +: 8];
         assign cst_at2[8*g +: 8] = window[8*(2+g) +: 8];
      end
   endgenerate

   always_comb begin
      ra = cls.has_reg ? window[15:12] : NOREG_ID;
      rb = cls.has_reg ? window[11:8]  : NOREG_ID;
      unique case (cls.cpos)
         CP_AT1:  cst = cst_at1;
         CP_AT2:  cst = cst_at2;
         default: cst = '0;
      endcase
   end

endmodule

// File: rtl/insn_window_decoder.sv
module insn_window_decoder
   import ixd_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int WIN_BYTES = 6,
   parameter int CONST_W   = 32,
   localparam int WIN_W    = 8 * WIN_BYTES,
   localparam int LEN_W    = 3
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [PC_W-1:0]    in_pc,
   input  logic [WIN_W-1:0]   in_window,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [3:0]         out_icode,
   output logic [3:0]         out_ifun,
   output logic [3:0]         out_ra,
   output logic [3:0]         out_rb,
   output logic [CONST_W-1:0] out_const,
   output logic [LEN_W-1:0]   out_len,
   output logic [PC_W-1:0]    out_next_pc,
   output logic               out_invalid,
   output logic               out_halt
);

   generate
      if (PC_W < 8) begin : g_bad_pc
         $error("insn_window_decoder: PC_W too small");
      end
   endgenerate

   ixd_class_t         cls;
   logic [3:0]         d_ra;
   logic [3:0]         d_rb;
   logic [CONST_W-1:0] d_cst;
   logic [PC_W-1:0]    d_npc;
   logic               take;

   ixd_classify u_cls (
      .op_byte (in_window[7:0]),
      .cls     (cls)
   );

   ixd_fields #(
      .WIN_BYTES (WIN_BYTES),
      .CONST_W   (CONST_W)
   ) u_fld (
      .window (in_window),
      .cls    (cls),
      .ra     (d_ra),
      .rb     (d_rb),
      .cst    (d_cst)
   );

   assign d_npc    = in_pc + PC_W'(cls.len);
   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
      end else if (take) begin
         out_valid <= 1'b1;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_icode   <= '0;
         out_ifun    <= '0;
         out_ra      <= NOREG_ID;
         out_rb      <= NOREG_ID;
         out_const   <= '0;
         out_len     <= LEN_W'(1);
         out_next_pc <= '0;
         out_invalid <= 1'b0;
         out_halt    <= 1'b0;
      end else if (take) begin
         out_icode   <= in_window[7:4];
         out_ifun    <= in_window[3:0];
         out_ra      <= d_ra;
         out_rb      <= d_rb;
         out_const   <= d_cst;
         out_len     <= cls.len;
         out_next_pc <= d_npc;
         out_invalid <= !cls.ok;
         out_halt    <= cls.halt;
      end
   end

   // R1: only the four legal lengths ever leave the stage
   a_r1_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_len == 3'd1 || out_len == 3'd2 || out_len == 3'd5 || out_len == 3'd6));

   // R4: jumps carry no register byte
   a_r4_jump_noreg: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_len == 3'd5) |-> (out_ra == NOREG_ID && out_rb == NOREG_ID));

   // R6: invalid results are fully neutralised
   a_r6_invalid_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_invalid) |-> (out_len == 3'd1 && out_ra == NOREG_ID &&
                                      out_rb == NOREG_ID && out_const == '0));

   // R7: halt never coexists with invalid, and only from opcode 1
   a_r7_halt_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_halt) |-> (!out_invalid && out_icode == 4'h1 && out_ifun == 4'h0));

   // R8: a stalled result holds
   a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_icode) && $stable(out_ifun) &&
                                     $stable(out_const) && $stable(out_next_pc) &&
                                     $stable(out_ra) && $stable(out_rb)));

endmodule

// File: tb/insn_window_decoder_tb.sv
module insn_window_decoder_tb;

   typedef struct packed {
      logic [3:0]  icode;
      logic [3:0]  ifun;
      logic [3:0]  ra;
      logic [3:0]  rb;
      logic [31:0] cst;
      logic [2:0]  len;
      logic [31:0] npc;
      logic        inv;
      logic        halt;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_pc = '0;
   logic [47:0] in_window = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [3:0]  out_icode, out_ifun, out_ra, out_rb;
   logic [31:0] out_const, out_next_pc;
   logic [2:0]  out_len;
   logic        out_invalid, out_halt;

   int n_tests = 0;
   int n_fail  = 0;
   int bp_pct  = 0;
   exp_t q[$];

   always #2.5 clk = ~clk;

   insn_window_decoder u_dut (
      .clk (clk), .rst_n (rst_n),
      .in_valid (in_valid), .in_ready (in_ready),
      .in_pc (in_pc), .in_window (in_window),
      .out_valid (out_valid), .out_ready (out_ready),
      .out_icode (out_icode), .out_ifun (out_ifun),
      .out_ra (out_ra), .out_rb (out_rb),
      .out_const (out_const), .out_len (out_len),
      .out_next_pc (out_next_pc), .out_invalid (out_invalid),
      .out_halt (out_halt)
   );

   function automatic exp_t predict(input logic [31:0] pc, input logic [47:0] w);
      exp_t e;
      logic [3:0] ic, fn;
      logic ok, reg_b;
      int cpos;
      ic = w[7:4];
      fn = w[3:0];
      ok = 1'b0; reg_b = 1'b0; cpos = 0;
      e = '0;
      e.len = 3'd1;
      case (ic)
         4'h0, 4'h1: ok = (fn == 0);
         4'h2: begin ok = (fn == 0); e.len = 3'd2; reg_b = 1'b1; end
         4'h3, 4'h4, 4'h5: begin ok = (fn == 0); e.len = 3'd6; reg_b = 1'b1; cpos = 2; end
         4'h6: begin ok = (fn <= 3); e.len = 3'd2; reg_b = 1'b1; end
         4'h7: begin ok = (fn <= 6); e.len = 3'd5; cpos = 1; end
         default: ok = 1'b0;
      endcase
      if (!ok) begin
         e.len = 3'd1; reg_b = 1'b0; cpos = 0;
      end
      e.icode = ic;
      e.ifun  = fn;
      e.ra    = reg_b ? w[15:12] : 4'h8;
      e.rb    = reg_b ? w[11:8]  : 4'h8;
      e.cst   = (cpos == 1) ? {w[39:32], w[31:24], w[23:16], w[15:8]} :
                (cpos == 2) ? {w[47:40], w[39:32], w[31:24], w[23:16]} : 32'h0;
      e.npc   = pc + 32'(e.len);
      e.inv   = !ok;
      e.halt  = ok && (ic == 4'h1);
      return e;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      n_tests++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic compare_out();
      exp_t e;
      if (q.size() == 0) begin
         chk("R8 unexpected output", 32'd1, 32'd0);
         return;
      end
      e = q.pop_front();
      chk("R2 icode", 32'(out_icode), 32'(e.icode));
      chk("R2 ifun", 32'(out_ifun), 32'(e.ifun));
      chk("R3 rA", 32'(out_ra), 32'(e.ra));
      chk("R3 rB", 32'(out_rb), 32'(e.rb));
      chk("R4 const", out_const, e.cst);
      chk("R1 len", 32'(out_len), 32'(e.len));
      chk("R5 next_pc", out_next_pc, e.npc);
      chk("R6 invalid", 32'(out_invalid), 32'(e.inv));
      chk("R7 halt", 32'(out_halt), 32'(e.halt));
   endtask

   // one cycle: drive at negedge, then resolve the handshakes of the coming edge
   task automatic step(input logic iv, input logic [31:0] pc, input logic [47:0] w, output logic taken);
      logic held_v;
      logic [31:0] held_c;
      @(negedge clk);
      held_v = out_valid;
      held_c = out_const;
      in_valid  = iv;
      in_pc     = pc;
      in_window = w;
      out_ready = ($urandom % 100) >= bp_pct;
      #1;
      chk("R8 in_ready", 32'(in_ready), 32'(!out_valid || out_ready));
      if (held_v) chk("R8 held const", out_const, held_c);
      if (out_valid && out_ready) compare_out();
      taken = iv && in_ready;
      if (taken) q.push_back(predict(pc, w));
   endtask

   task automatic send(input logic [31:0] pc, input logic [47:0] w);
      logic t;
      t = 1'b0;
      while (!t) step(1'b1, pc, w, t);
   endtask

   task automatic drain();
      logic t;
      for (int i = 0; i < 20 && q.size() > 0; i++) step(1'b0, 32'h0, 48'h0, t);
      chk("R8 drained", 32'(q.size()), 32'd0);
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      #1;
      chk("R9 reset out_valid", 32'(out_valid), 32'd0);
      chk("R9 reset in_ready", 32'(in_ready), 32'd1);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // directed corners, no backpressure
      bp_pct = 0;
      send(32'h0000_0100, 48'h0000_abcd_8230);      // R4 immediate 0xabcd, rB=2
      send(32'h0000_0106, 48'hffff_fff4_1550);      // R4 displacement -12, rA=1 rB=5
      send(32'h0000_0200, 48'h0000_0000_0010);      // R7 halt
      send(32'h0000_0300, 48'h0000_0000_0064);      // R6 arith function 4
      send(32'h0000_0300, 48'h0000_0000_0077);      // R6 jump function 7
      send(32'h0000_0300, 48'h0000_0000_0021);      // R6 move function 1
      send(32'h0000_0300, 48'h1234_5678_9a11);      // R6/R7 halt with function 1
      send(32'h0000_0300, 48'h0000_0000_4480);      // R6 opcode 8
      send(32'hffff_fffe, 48'h0403_0201_6440);      // R5 wrap of next_pc
      send(32'h0000_0400, 48'h00aa_bbcc_dd76);      // R4 jump target bytes 1..4
      send(32'h0000_0500, 48'h0000_0000_0660);      // R3 arith regs
      send(32'h0000_0500, 48'h0000_0000_0000);      // R1 nop
      drain();

      // random stream with backpressure
      for (int phase = 0; phase < 3; phase++) begin
         bp_pct = phase * 35;
         for (int i = 0; i < 400; i++) begin
            logic [47:0] w;
            logic t;
            w = {$urandom, $urandom};
            w[7:4] = 4'($urandom % 9);
            w[3:0] = 4'($urandom % 8);
            if (($urandom % 4) != 0) send($urandom, w);
            else step(1'b0, 32'h0, 48'h0, t);
         end
         drain();
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule